// File: doc/BRIEF.md
# I2C Target Byte Controller

This block is the target side of an I2C link. A host reaches it through four byte-wide registers: data, control, status and own address. It watches SCL and SDA through a small synchronizer and flags START and STOP conditions. After each START it collects a 7-bit address and a R/W bit. If the address equals the programmed own address, it acknowledges the byte and raises an interrupt. It then holds SCL low until the host services it.

The direction of the transfer is handled in two phases. The status register reports the R/W bit of the matched address byte, but only while the addressed flag is set. Once data flows, the direction is set by a transmit-mode bit that the host writes into the control register. The block stretches SCL low after every byte. It lets SCL go only when the host accesses the data register in the way that suits the current mode: a write in transmit mode, or a read in receive mode. Both lines are driven open-drain, so each output only asks for its line to be pulled low.

Register map, by `reg_addr`: 0 = data, 1 = control, 2 = status (read-only), 3 = own address in bits [6:0]. Control bits: [6] interrupt enable, [4] transmit mode, [3] answer received bytes with NACK. Status bits: [0] interrupt pending, [1] addressed as target, [2] captured R/W bit (shown only while bit 1 is set), [3] acknowledge bit last received from the master (1 = NACK), [5] bus busy (between START and STOP).

Top module: `i2c_tgt_top`

## Requirements
- R1: After reset, status and control read 0x00, both open-drain outputs are released and `irq` is low.
- R2: When an address byte matches the own address, the block drives ACK in the ninth clock. It then sets status bits [0] and [1] and shows the R/W bit in status bit [2]. With control bit [6] set, `irq` rises at the end of that ninth clock.
- R3: An address that does not match gets no ACK and raises no interrupt. The block stays idle until the next START.
- R4: After each acknowledged byte, SCL is held low until the host writes the data register in transmit mode or reads it in receive mode. An access of the data register in the other mode leaves SCL held low.
- R5: A host write to the control register clears status bit [1]. The interrupt of a data byte also leaves bit [1] cleared.
- R6: In receive mode, data bits are shifted in MSB first and the byte appears in the data register when the interrupt is raised. The block sends ACK, or NACK when control bit [3] is set.
- R7: In transmit mode, the byte written to the data register is shifted out MSB first, and SDA changes only while SCL is low. If the master answers with ACK, the block stretches again and waits for the next byte. If it answers with NACK, status bit [3] is set and SDA is released.
- R8: A STOP condition returns the block to idle, releases both lines and clears status bit [5].
- R9: If an address match and a host write to the control register fall in the same clock cycle, status bits [1] and [0] end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (side effects) |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The two events that can fall in the same cycle are the address-match event, which sets the addressed flag, and a host write to the control register, which clears it. The bench provokes the overlap in the transmit test. The emulated master drops SCL at the end of the address acknowledge, and a known number of clocks later, equal to the synchronizer delay, it issues the control write that selects transmit mode. A following status read must still show the addressed flag and the pending interrupt, so the set must win over the clear.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_DATA = 2'd0;
  localparam logic [REG_AW-1:0] RA_CTRL = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd2;
  localparam logic [REG_AW-1:0] RA_OWN  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_HOLD, ST_TX, ST_TACK, ST_RX, ST_RACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_q, sda_q, scl_d, sda_d;

  always_comb begin
    scl_d = {scl_q[DEPTH-2:0], scl_i};
    sda_d = {sda_q[DEPTH-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    scl_s    = scl_q[SYNC_STAGES-1];
    sda_s    = sda_q[SYNC_STAGES-1];
    scl_rise = scl_s & ~scl_q[SYNC_STAGES];
    scl_fall = ~scl_s & scl_q[SYNC_STAGES];
    start_p  = scl_s & scl_q[SYNC_STAGES] & ~sda_s & sda_q[SYNC_STAGES];
    stop_p   = scl_s & scl_q[SYNC_STAGES] & sda_s & ~sda_q[SYNC_STAGES];
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic [AW-1:0] own_addr,
  input  logic          tx_mode,
  input  logic          nak_mode,
  input  logic [DW-1:0] tx_byte,
  input  logic          release_p,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          addr_hit,
  output logic          byte_done,
  output logic          load_rx,
  output logic [DW-1:0] rx_byte,
  output logic          rw_bit,
  output logic          mst_nak
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  tgt_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sr_q, sr_d;
  logic          rw_q, rw_d, nak_q, nak_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sr_d = sr_q; rw_d = rw_q; nak_d = nak_q;
    addr_hit = 1'b0; byte_done = 1'b0; load_rx = 1'b0;
    if (stop_p) begin
      st_d = ST_IDLE;
    end else if (start_p) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sr_d  = {sr_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (st_q == ST_RX) st_d = ST_RACK;
            else if (sr_q[DW-1:1] == own_addr) begin
              st_d = ST_AACK;
              rw_d = sr_q[0];
            end else st_d = ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          st_d = ST_HOLD;
          addr_hit = 1'b1;
        end
        ST_HOLD: if (release_p) begin
          cnt_d = '0;
          if (tx_mode) begin
            st_d = ST_TX;
            sr_d = tx_byte;
          end else st_d = ST_RX;
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == LAST) st_d = ST_TACK;
          else begin
            sr_d  = {sr_q[DW-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TACK: begin
          if (scl_rise) nak_d = sda_s;
          else if (scl_fall) begin
            byte_done = 1'b1;
            st_d = nak_q ? ST_IDLE : ST_HOLD;
          end
        end
        ST_RACK: if (scl_fall) begin
          st_d = ST_HOLD;
          byte_done = 1'b1;
          load_rx = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; rw_q <= 1'b0; nak_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sr_q <= sr_d; rw_q <= rw_d; nak_q <= nak_d;
    end
  end

  always_comb begin
    scl_oe  = (st_q == ST_HOLD);
    sda_oe  = (st_q == ST_AACK) || (st_q == ST_TX && !sr_q[DW-1]) ||
              (st_q == ST_RACK && !nak_mode);
    rx_byte = sr_q;
    rw_bit  = rw_q;
    mst_nak = nak_q;
  end

  // R7: SDA only moves while SCL is low (bus conditions excepted)
  a_r7_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(start_p || stop_p)));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              addr_hit,
  input  logic              byte_done,
  input  logic              load_rx,
  input  logic [DW-1:0]     rx_byte,
  input  logic              rw_bit,
  input  logic              mst_nak,
  input  logic              start_p,
  input  logic              stop_p,
  output logic [AW-1:0]     own_addr,
  output logic              tx_mode,
  output logic              nak_mode,
  output logic [DW-1:0]     tx_byte,
  output logic              release_p,
  output logic              irq
);
  logic [DW-1:0] data_q, data_d;
  logic [AW-1:0] own_q, own_d;
  logic ie_q, ie_d, tx_q, tx_d, nk_q, nk_d;
  logic ifl_q, ifl_d, aas_q, aas_d, rxak_q, rxak_d, busy_q, busy_d;
  logic wr_data, rd_data, wr_ctrl, wr_own;

  always_comb begin
    wr_data = reg_wr && reg_addr == RA_DATA;
    rd_data = reg_rd && reg_addr == RA_DATA;
    wr_ctrl = reg_wr && reg_addr == RA_CTRL;
    wr_own  = reg_wr && reg_addr == RA_OWN;

    data_d = data_q; own_d = own_q; ie_d = ie_q; tx_d = tx_q; nk_d = nk_q;
    ifl_d = ifl_q; aas_d = aas_q; rxak_d = rxak_q; busy_d = busy_q;
    if (wr_data) data_d = reg_wdata;
    else if (load_rx) data_d = rx_byte;
    if (wr_own) own_d = reg_wdata[AW-1:0];
    if (wr_ctrl) begin
      ie_d = reg_wdata[6];
      tx_d = reg_wdata[4];
      nk_d = reg_wdata[3];
    end
    if (wr_data || rd_data || wr_ctrl) ifl_d = 1'b0;
    if (addr_hit || byte_done) ifl_d = 1'b1;
    if (wr_ctrl || byte_done) aas_d = 1'b0;
    if (addr_hit) aas_d = 1'b1;
    if (byte_done && tx_q) rxak_d = mst_nak;
    if (start_p) busy_d = 1'b1;
    if (stop_p) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; own_q <= '0; ie_q <= 1'b0; tx_q <= 1'b0; nk_q <= 1'b0;
      ifl_q <= 1'b0; aas_q <= 1'b0; rxak_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      data_q <= data_d; own_q <= own_d; ie_q <= ie_d; tx_q <= tx_d; nk_q <= nk_d;
      ifl_q <= ifl_d; aas_q <= aas_d; rxak_q <= rxak_d; busy_q <= busy_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_DATA: reg_rdata = data_q;
      RA_CTRL: reg_rdata = {1'b0, ie_q, 1'b0, tx_q, nk_q, 3'b000};
      RA_STAT: reg_rdata = {2'b00, busy_q, 1'b0, rxak_q, rw_bit & aas_q, aas_q, ifl_q};
      default: reg_rdata = {{(DW-AW){1'b0}}, own_q};
    endcase
    own_addr  = own_q;
    tx_mode   = tx_q;
    nak_mode  = nk_q;
    tx_byte   = wr_data ? reg_wdata : data_q;
    release_p = (wr_data && tx_q) || (rd_data && !tx_q);
    irq       = ifl_q && ie_q;
  end

  // R9: address match wins over a same-cycle control write
  a_r9_hit_sets_aas: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> (aas_q && ifl_q));
  // R5: a data-byte event leaves the addressed flag clear
  a_r5_byte_clears_aas: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !addr_hit) |=> !aas_q);
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
  logic addr_hit, byte_done, load_rx, rw_bit, mst_nak;
  logic tx_mode, nak_mode, release_p;
  logic [DW-1:0] rx_byte, tx_byte;
  logic [AW-1:0] own_addr;

  i2c_tgt_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  i2c_tgt_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .own_addr(own_addr), .tx_mode(tx_mode), .nak_mode(nak_mode),
    .tx_byte(tx_byte), .release_p(release_p), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .addr_hit(addr_hit), .byte_done(byte_done), .load_rx(load_rx),
    .rx_byte(rx_byte), .rw_bit(rw_bit), .mst_nak(mst_nak));

  i2c_tgt_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_hit(addr_hit), .byte_done(byte_done), .load_rx(load_rx),
    .rx_byte(rx_byte), .rw_bit(rw_bit), .mst_nak(mst_nak),
    .start_p(start_p), .stop_p(stop_p), .own_addr(own_addr),
    .tx_mode(tx_mode), .nak_mode(nak_mode), .tx_byte(tx_byte),
    .release_p(release_p), .irq(irq));

  // R4: the stretch ends only on a matching data access or a bus condition
  a_r4_release_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(release_p || start_p || stop_p));
  // R8: STOP frees both lines
  a_r8_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (!scl_oe && !sda_oe));
  // R3: a mismatched address never raises the interrupt without a hit
  a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(addr_hit || byte_done || reg_wr));
endmodule

// File: tb/i2c_tgt_top_bench.sv
module i2c_tgt_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk, rst_n;
  logic scl_oe, sda_oe, irq;
  logic h_wr, h_rd;
  logic [1:0] h_addr;
  logic [7:0] h_wdata, reg_rdata;
  logic m_scl_low, m_sda_low;
  logic scl_line, sda_line;
  int n_total, n_fail;
  logic [7:0] exp_q[$];

  assign scl_line = !(scl_oe || m_scl_low);
  assign sda_line = !(sda_oe || m_sda_low);

  i2c_tgt_top u_i2c_tgt_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(h_wr), .reg_rd(h_rd),
    .reg_addr(h_addr), .reg_wdata(h_wdata), .reg_rdata(reg_rdata), .irq(irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic wait_h(); repeat (HALF) @(negedge clk); endtask
  task automatic wait_irq(); while (!irq) @(negedge clk); endtask

  task automatic m_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0; wait_h();
    m_sda_low = 1'b1; wait_h();
    m_scl_low = 1'b1; wait_h();
  endtask

  task automatic m_stop();
    repeat (2) @(negedge clk);
    m_sda_low = 1'b1; wait_h();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_h(); m_sda_low = 1'b0; wait_h();
  endtask

  task automatic m_wbit(input logic b);
    repeat (2) @(negedge clk);
    m_sda_low = !b; wait_h();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_h(); m_scl_low = 1'b1;
  endtask

  task automatic m_rbit(output logic b, input bit coll);
    repeat (2) @(negedge clk);
    m_sda_low = 1'b0; wait_h();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    repeat (HALF/2) @(negedge clk);
    b = sda_line;
    repeat (HALF/2) @(negedge clk);
    m_scl_low = 1'b1;
    if (coll) begin
      // control write lands in the cycle of the address-match event (R9)
      repeat (2) @(negedge clk);
      h_addr = 2'd1; h_wdata = 8'h50; h_wr = 1'b1;
      @(negedge clk); h_wr = 1'b0;
    end
  endtask

  task automatic m_wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
  endtask

  task automatic m_rbyte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b, 1'b0); v[i] = b; end
  endtask

  logic done;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic ak;
    done = 1'b0; n_total = 0; n_fail = 0;
    h_wr = 1'b0; h_rd = 1'b0; h_addr = 2'd0; h_wdata = 8'h00;
    m_scl_low = 1'b0; m_sda_low = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    hrd(2'd2, d); chk(d == 8'h00, "R1 status", d, 8'h00);
    hrd(2'd1, d); chk(d == 8'h00, "R1 control", d, 8'h00);
    chk({scl_line, sda_line, irq} == 3'b110, "R1 lines/irq", {scl_line, sda_line, irq}, 3'b110);

    hwr(2'd3, 8'h2A);
    hwr(2'd1, 8'h40);

    // R3: foreign address
    m_start(); m_wbyte({7'h15, 1'b0}); m_rbit(ak, 1'b0);
    chk(ak == 1'b1, "R3 no ack", ak, 1);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R3 no irq", irq, 0);
    hrd(2'd2, d); chk(d[1:0] == 2'b00, "R3 status", d, 8'h20);
    m_stop();

    // receive test: master writes, host reads
    fork
      begin
        m_start(); m_wbyte({7'h2A, 1'b0}); m_rbit(ak, 1'b0);
        chk(ak == 1'b0, "R2 addr ack", ak, 0);
        exp_q.push_back(8'hA5); m_wbyte(8'hA5); m_rbit(ak, 1'b0);
        chk(ak == 1'b0, "R6 data ack", ak, 0);
        exp_q.push_back(8'h3C); m_wbyte(8'h3C); m_rbit(ak, 1'b0);
        chk(ak == 1'b1, "R6 data nack", ak, 1);
        m_stop();
      end
      begin
        wait_irq(); hrd(2'd2, d);
        chk(d == 8'h23, "R2 addressed status", d, 8'h23);
        hwr(2'd1, 8'h40); hrd(2'd2, d);
        chk(d == 8'h20, "R5 ctrl write clears aas", d, 8'h20);
        hrd(2'd0, d);
        for (int k = 0; k < 2; k++) begin
          wait_irq(); hrd(2'd2, d);
          chk(d == 8'h21, "R5 data irq leaves aas clear", d, 8'h21);
          if (k == 0) hwr(2'd1, 8'h48);
          hrd(2'd0, d);
          if (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(d == e, "R6 received byte", d, e);
          end else chk(1'b0, "R6 scoreboard empty", 0, 1);
        end
      end
    join
    repeat (10) @(negedge clk);
    hrd(2'd2, d); chk(d[5] == 1'b0, "R8 busy clear", d[5], 0);

    // transmit test: master reads, host writes
    fork
      begin
        m_start(); m_wbyte({7'h2A, 1'b1}); m_rbit(ak, 1'b1);
        chk(ak == 1'b0, "R2 read addr ack", ak, 0);
        for (int k = 0; k < 2; k++) begin
          logic [7:0] got, e;
          m_rbyte(got);
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hXX;
          chk(got == e, "R7 transmitted byte", got, e);
          m_wbit(k == 1);
        end
        m_stop();
      end
      begin
        wait_irq(); hrd(2'd2, d);
        chk(d == 8'h27, "R9 aas kept on same-cycle ctrl write", d, 8'h27);
        hrd(2'd0, d);
        repeat (40) @(negedge clk);
        chk(scl_line == 1'b0, "R4 wrong-mode access keeps stretch", scl_line, 0);
        exp_q.push_back(8'h96); hwr(2'd0, 8'h96);
        wait_irq(); hrd(2'd2, d);
        chk(d == 8'h21, "R7 master ack status", d, 8'h21);
        exp_q.push_back(8'h0F); hwr(2'd0, 8'h0F);
        wait_irq(); hrd(2'd2, d);
        chk(d == 8'h29, "R7 master nack status", d, 8'h29);
        chk(sda_oe == 1'b0, "R7 sda released after nack", sda_oe, 0);
      end
    join
    repeat (10) @(negedge clk);
    hrd(2'd2, d); chk(d[5] == 1'b0, "R8 busy clear after stop", d[5], 0);
    chk({scl_line, sda_line} == 2'b11, "R8 lines released", {scl_line, sda_line}, 2'b11);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule